// File: doc/BRIEF.md
# Descriptor-Table Register Store Unit

This unit carries out the store of the interrupt descriptor table register to memory. The register is a 16-bit limit and a 64-bit base. A one-cycle start pulse hands the unit the processor mode, the operand size, the effective address, the segment checks that earlier logic has already resolved, the privilege level, the alignment-check enable, a lock-prefix flag and a flag that marks a register destination. In the cycle that start is sampled, the unit decides whether the operation faults.

If the operation faults, the unit writes nothing and pulses a fault indication with a 3-bit code. Otherwise it builds the memory image for the mode and operand size and sends that image one byte per accepted cycle on a byte write port with a valid/ready handshake. Bytes go out in ascending address order. When the last byte has been accepted, the unit pulses done. The store changes no status flags.

Top module: `dtr_store_unit`

## Requirements
- R1: Mode is encoded 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit. In every mode the limit is written little-endian: limit[7:0] at the effective address and limit[15:8] at the address one above it.
- R2: Outside 64-bit mode, with `op32`=1, exactly 6 bytes are written, and offsets 2 to 5 carry base[31:0] little-endian.
- R3: Outside 64-bit mode, with `op32`=0, exactly 6 bytes are written. Offsets 2 to 4 carry base[23:0] little-endian and offset 5 is written as 0x00.
- R4: In 64-bit mode exactly 10 bytes are written, with offsets 2 to 9 carrying base[63:0] little-endian. `op32` has no effect in this mode.
- R5: Byte k goes to address eaddr+k, in ascending k. While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` hold their values.
- R6: `done` is high for exactly one cycle, in the cycle after the last byte is accepted. A start pulse that arrives while an operation is in progress is ignored.
- R7: Invalid-opcode (code 1) is raised in any mode when `lock_prefix`=1. It is also raised in protected, compatibility and 64-bit mode when `dest_is_reg`=1. It has the highest priority.
- R8: In 64-bit mode, an address whose bits 63 to 47 are not all equal raises general-protection (code 2), or stack fault (code 3) when `seg_is_ss`=1. The segment limit, writable and null-selector inputs have no effect in this mode.
- R9: In protected and compatibility mode, general-protection (code 2) is raised when `seg_writable`=0, or when `seg_null_sel`=1 with `seg_is_ss`=0. Otherwise `seg_limit_viol`=1 raises stack fault (code 3) through SS and general-protection elsewhere. In real and virtual-8086 mode, only the limit rule applies.
- R10: Alignment-check (code 4) is raised when `ac_enable`=1 and eaddr[1:0] is nonzero. This applies in protected, compatibility and 64-bit mode only when `cpl`=3, in virtual-8086 mode at any privilege level, and never in real mode. It ranks below the code 2 and code 3 faults.
- R11: A faulting operation writes no byte. `fault` is high for exactly one cycle, the cycle after start, with its code on `fault_code`. `fault_code` is 0 whenever `fault` is low.
- R12: While reset is asserted, `wr_valid`, `done`, `fault` and `fault_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a store |
| mode | input | 3 | Processor mode (R1 encoding) |
| op32 | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| eaddr | input | 64 | Effective address of the destination |
| seg_is_ss | input | 1 | Reference goes through the stack segment |
| seg_limit_viol | input | 1 | Address lies outside the segment limit |
| seg_writable | input | 1 | Segment is writable |
| seg_null_sel | input | 1 | Segment register holds a null selector |
| cpl | input | 2 | Current privilege level |
| ac_enable | input | 1 | Alignment checking enabled |
| lock_prefix | input | 1 | Lock prefix present |
| dest_is_reg | input | 1 | Destination operand is a register |
| idt_limit | input | 16 | Table limit to store |
| idt_base | input | 64 | Table base to store |
| wr_valid | output | 1 | Byte write request |
| wr_addr | output | 64 | Byte write address |
| wr_data | output | 8 | Byte write data |
| wr_ready | input | 1 | Memory accepts the byte this cycle |
| done | output | 1 | Store completed |
| fault | output | 1 | Store aborted by a fault |
| fault_code | output | 3 | 1 UD, 2 GP, 3 SS, 4 AC, 0 none |

## Verification
Some properties hold on every cycle, and the assertions check them continuously. Write data and address stay steady under back-pressure. Each accepted byte is followed by the next address. Done and fault are single, mutually exclusive pulses, and no write accompanies a fault. A locked request always yields code 1, and a start that arrives mid-transfer produces no fault. The assertions do not check image contents, byte counts or the precedence among the fault rules across modes. Only the bench's scenarios show these, by comparing every emitted byte and code against values derived independently from the requirements.

// File: rtl/dtr_store_pkg.sv
package dtr_store_pkg;

  typedef enum logic [2:0] {
    MD_REAL   = 3'd0,
    MD_V86    = 3'd1,
    MD_PROT   = 3'd2,
    MD_COMPAT = 3'd3,
    MD_LONG   = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_UD   = 3'd1,
    FC_GP   = 3'd2,
    FC_SS   = 3'd3,
    FC_AC   = 3'd4
  } fcode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_DONE  = 2'd2,
    ST_FAULT = 2'd3
  } state_e;

endpackage

// File: rtl/dtr_fault_eval.sv
module dtr_fault_eval
  import dtr_store_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int CANON_BIT  = 47,
  parameter int ALIGN_LOG2 = 2
) (
  input  mode_e                      mode,
  input  logic                       lock_prefix,
  input  logic                       dest_is_reg,
  input  logic [ADDR_W-1:CANON_BIT]  addr_hi,
  input  logic [ALIGN_LOG2-1:0]      addr_lo,
  input  logic                       seg_is_ss,
  input  logic                       seg_limit_viol,
  input  logic                       seg_writable,
  input  logic                       seg_null_sel,
  input  logic [1:0]                 cpl,
  input  logic                       ac_enable,
  output fcode_e                     code
);

  logic   prot_like;
  logic   ud_hit;
  logic   canon_ok;
  logic   ac_hit;
  fcode_e seg_code;
  fcode_e lim_code;

  assign prot_like = (mode == MD_PROT) || (mode == MD_COMPAT);
  assign ud_hit    = lock_prefix || (dest_is_reg && (prot_like || mode == MD_LONG));
  assign canon_ok  = (&addr_hi) || ~(|addr_hi);
  assign lim_code  = seg_is_ss ? FC_SS : FC_GP;

  always_comb begin
    seg_code = FC_NONE;
    case (mode)
      MD_LONG: begin
        if (!canon_ok) seg_code = lim_code;
      end
      MD_PROT, MD_COMPAT: begin
        if (!seg_writable || (seg_null_sel && !seg_is_ss)) seg_code = FC_GP;
        else if (seg_limit_viol)                            seg_code = lim_code;
      end
      MD_REAL, MD_V86: begin
        if (seg_limit_viol) seg_code = lim_code;
      end
      default: seg_code = FC_NONE;
    endcase
  end

  assign ac_hit = ac_enable && (|addr_lo) &&
                  ((mode == MD_V86) ||
                   ((prot_like || mode == MD_LONG) && cpl == 2'd3));

  always_comb begin
    if (ud_hit)                   code = FC_UD;
    else if (seg_code != FC_NONE) code = seg_code;
    else if (ac_hit)              code = FC_AC;
    else                          code = FC_NONE;
  end

endmodule

// File: rtl/dtr_image_build.sv
module dtr_image_build
  import dtr_store_pkg::*;
#(
  parameter int LIMIT_W = 16,
  parameter int BASE_W  = 64,
  parameter int IDX_W   = 4
) (
  input  mode_e                        mode,
  input  logic                         op32,
  input  logic [LIMIT_W-1:0]           limit,
  input  logic [BASE_W-1:0]            base,
  output logic [LIMIT_W+BASE_W-1:0]    image,
  output logic [IDX_W-1:0]             nbytes
);

  localparam int WIDE_BYTES  = (LIMIT_W + BASE_W) / 8;
  localparam int MID_BASE_W  = 32;
  localparam int NARROW_W    = 24;
  localparam int SHORT_BYTES = (LIMIT_W + MID_BASE_W) / 8;

  always_comb begin
    image                = '0;
    image[LIMIT_W-1:0]   = limit;
    if (mode == MD_LONG) begin
      image[LIMIT_W +: BASE_W] = base;
      nbytes = IDX_W'(WIDE_BYTES);
    end else if (op32) begin
      image[LIMIT_W +: MID_BASE_W] = base[MID_BASE_W-1:0];
      nbytes = IDX_W'(SHORT_BYTES);
    end else begin
      image[LIMIT_W +: NARROW_W] = base[NARROW_W-1:0];
      nbytes = IDX_W'(SHORT_BYTES);
    end
  end

endmodule

// File: rtl/dtr_store_unit.sv
module dtr_store_unit
  import dtr_store_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LIMIT_W    = 16,
  parameter int BASE_W     = 64,
  parameter int CANON_BIT  = 47,
  parameter int ALIGN_LOG2 = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          mode,
  input  logic                op32,
  input  logic [ADDR_W-1:0]   eaddr,
  input  logic                seg_is_ss,
  input  logic                seg_limit_viol,
  input  logic                seg_writable,
  input  logic                seg_null_sel,
  input  logic [1:0]          cpl,
  input  logic                ac_enable,
  input  logic                lock_prefix,
  input  logic                dest_is_reg,
  input  logic [LIMIT_W-1:0]  idt_limit,
  input  logic [BASE_W-1:0]   idt_base,
  output logic                wr_valid,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [7:0]          wr_data,
  input  logic                wr_ready,
  output logic                done,
  output logic                fault,
  output logic [2:0]          fault_code
);

  localparam int IMG_W     = LIMIT_W + BASE_W;
  localparam int IMG_BYTES = IMG_W / 8;
  localparam int IDX_W     = $clog2(IMG_BYTES);

  state_e             state_q, state_d;
  logic [IMG_W-1:0]   img_q, img_c;
  logic [IDX_W-1:0]   cnt_q, cnt_c;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [ADDR_W-1:0]  addr_q;
  fcode_e             code_q, code_c;
  logic               load_en;
  logic               code_en;
  logic               idx_en;
  logic               busy;
  logic [7:0]         img_bytes [IMG_BYTES];

  dtr_fault_eval #(
    .ADDR_W(ADDR_W), .CANON_BIT(CANON_BIT), .ALIGN_LOG2(ALIGN_LOG2)
  ) u_fault (
    .mode           (mode_e'(mode)),
    .lock_prefix    (lock_prefix),
    .dest_is_reg    (dest_is_reg),
    .addr_hi        (eaddr[ADDR_W-1:CANON_BIT]),
    .addr_lo        (eaddr[ALIGN_LOG2-1:0]),
    .seg_is_ss      (seg_is_ss),
    .seg_limit_viol (seg_limit_viol),
    .seg_writable   (seg_writable),
    .seg_null_sel   (seg_null_sel),
    .cpl            (cpl),
    .ac_enable      (ac_enable),
    .code           (code_c)
  );

  dtr_image_build #(
    .LIMIT_W(LIMIT_W), .BASE_W(BASE_W), .IDX_W(IDX_W)
  ) u_image (
    .mode   (mode_e'(mode)),
    .op32   (op32),
    .limit  (idt_limit),
    .base   (idt_base),
    .image  (img_c),
    .nbytes (cnt_c)
  );

  assign busy = (state_q != ST_IDLE);

  // next-state and enables
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    load_en = 1'b0;
    code_en = 1'b0;
    idx_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (code_c != FC_NONE) begin
            state_d = ST_FAULT;
            code_en = 1'b1;
          end else begin
            state_d = ST_SEND;
            load_en = 1'b1;
            idx_en  = 1'b1;
            idx_d   = '0;
          end
        end
      end
      ST_SEND: begin
        if (wr_ready) begin
          if (idx_q == cnt_q - 1'b1) begin
            state_d = ST_DONE;
          end else begin
            idx_en = 1'b1;
            idx_d  = idx_q + 1'b1;
          end
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      img_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      code_q  <= FC_NONE;
    end else begin
      state_q <= state_d;
      if (load_en) begin
        img_q  <= img_c;
        cnt_q  <= cnt_c;
        addr_q <= eaddr;
      end
      if (idx_en)  idx_q  <= idx_d;
      if (code_en) code_q <= code_c;
    end
  end

  for (genvar g = 0; g < IMG_BYTES; g++) begin : g_unpack
    assign img_bytes[g] = img_q[g*8 +: 8];
  end

  assign wr_valid   = (state_q == ST_SEND);
  assign wr_addr    = addr_q + {{(ADDR_W-IDX_W){1'b0}}, idx_q};
  assign wr_data    = img_bytes[idx_q];
  assign done       = (state_q == ST_DONE);
  assign fault      = (state_q == ST_FAULT);
  assign fault_code = fault ? code_q : FC_NONE;

endmodule

// File: rtl/dtr_store_checker.sv
module dtr_store_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              lock_prefix,
  input logic              busy,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              done,
  input logic              fault,
  input logic [2:0]        fault_code
);

  a_r11_silent_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !wr_valid);

  a_r11_fault_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  a_r11_code_only_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> fault_code == 3'd0);

  a_r11_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_code >= 3'd1 && fault_code <= 3'd4));

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_not_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  a_r6_done_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_valid && wr_ready));

  a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wr_valid) |=> !fault);

  a_r5_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r5_next_address: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!wr_valid || wr_addr == $past(wr_addr) + 1'b1));

  a_r7_lock_is_ud: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && lock_prefix) |=> (fault && fault_code == 3'd1));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r12_quiet_in_reset: assert (!wr_valid && !done && !fault && fault_code == 3'd0);
    end
  end

endmodule

bind dtr_store_unit dtr_store_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dtr_store_unit_bench.sv
module dtr_store_unit_bench;

  typedef struct packed {
    logic [2:0]  md;
    logic        op32;
    logic        lk;
    logic        dreg;
    logic        ss;
    logic        limv;
    logic        wrt;
    logic        nul;
    logic [1:0]  cpl;
    logic        ac;
    logic [63:0] addr;
    logic [2:0]  ecode;
  } vec_t;

  localparam logic [63:0] A_OK  = 64'h0000_0000_0001_2340;
  localparam logic [63:0] A_ODD = 64'h0000_0000_0001_2341;
  localparam logic [63:0] A_NC  = 64'h0000_8000_0000_0000;
  localparam logic [63:0] A_HI  = 64'hFFFF_8000_0000_1000;
  localparam int NV = 21;

  // md op32 lk dreg ss limv wrt nul cpl ac addr ecode
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, A_OK,  3'd0}, // R2 real 32
    '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, A_OK,  3'd0}, // R3 real 16
    '{3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, A_OK,  3'd0}, // R2 prot
    '{3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, A_OK,  3'd0}, // R4 op32 ignored
    '{3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, A_OK,  3'd0}, // R3 compat
    '{3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, A_OK,  3'd1}, // R7 lock prot
    '{3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, A_OK,  3'd1}, // R7 lock over limit
    '{3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, A_NC,  3'd1}, // R7 reg dest long
    '{3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, A_NC,  3'd2}, // R8 noncanon GP
    '{3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, A_NC,  3'd3}, // R8 noncanon SS
    '{3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, A_HI,  3'd0}, // R8 seg ignored
    '{3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, A_OK,  3'd2}, // R9 not writable
    '{3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, A_OK,  3'd2}, // R9 null sel
    '{3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, A_OK,  3'd3}, // R9 limit via SS
    '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, A_OK,  3'd2}, // R9 v86 limit
    '{3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, A_OK,  3'd3}, // R9 real SS, R7 reg ok
    '{3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b1, A_ODD, 3'd4}, // R10 prot cpl3
    '{3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, A_ODD, 3'd0}, // R10 prot cpl0
    '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, A_ODD, 3'd4}, // R10 v86 any cpl
    '{3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b1, A_ODD, 3'd0}, // R10 real never
    '{3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 1'b1, A_ODD, 3'd2}  // R10 below GP
  };

  logic        clk, rst_n, start;
  logic [2:0]  mode;
  logic        op32, seg_is_ss, seg_limit_viol, seg_writable, seg_null_sel;
  logic [1:0]  cpl;
  logic        ac_enable, lock_prefix, dest_is_reg;
  logic [63:0] eaddr, idt_base, wr_addr;
  logic [15:0] idt_limit;
  logic        wr_valid, wr_ready, done, fault;
  logic [7:0]  wr_data;
  logic [2:0]  fault_code;

  int total = 0;
  int bad   = 0;

  logic [63:0] got_addr [16];
  logic [7:0]  got_data [16];
  int          ngot;
  logic        saw_done, saw_fault;
  logic [2:0]  got_code;

  dtr_store_unit u_dtr_store_unit (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [2:0] md, input logic o32,
      input logic [15:0] lim, input logic [63:0] b, input int k);
    int j;
    j = k - 2;
    if (k == 0) return lim[7:0];
    if (k == 1) return lim[15:8];
    if (md == 3'd4) return b[j*8 +: 8];
    if (o32)        return b[j*8 +: 8];
    if (j < 3)      return b[j*8 +: 8];
    return 8'h00;
  endfunction

  task automatic run_op(input vec_t v, input logic [15:0] lim, input logic [63:0] b,
                        input bit stall, input bit poke);
    @(negedge clk);
    mode = v.md; op32 = v.op32; lock_prefix = v.lk; dest_is_reg = v.dreg;
    seg_is_ss = v.ss; seg_limit_viol = v.limv; seg_writable = v.wrt;
    seg_null_sel = v.nul; cpl = v.cpl; ac_enable = v.ac; eaddr = v.addr;
    idt_limit = lim; idt_base = b; start = 1'b1;
    ngot = 0; saw_done = 1'b0; saw_fault = 1'b0; got_code = 3'd0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (poke && c == 2) begin start = 1'b1; lock_prefix = 1'b1; end
      else start = 1'b0;
      wr_ready = stall ? (c % 3 != 1) : 1'b1;
      #1;
      if (wr_valid && wr_ready && ngot < 16) begin
        got_addr[ngot] = wr_addr; got_data[ngot] = wr_data; ngot++;
      end
      if (done)  begin saw_done = 1'b1; break; end
      if (fault) begin saw_fault = 1'b1; got_code = fault_code; break; end
    end
    wr_ready = 1'b1;
    @(negedge clk); #1;
    chk("R6/R11 pulse ends", {62'd0, done, fault}, 64'd0);
  endtask

  task automatic judge(input vec_t v, input logic [15:0] lim, input logic [63:0] b);
    string tag;
    int n;
    if (v.ecode == 3'd1)      tag = "R7";
    else if (v.ecode == 3'd4) tag = "R10";
    else if (v.ecode != 3'd0) tag = (v.md == 3'd4) ? "R8" : "R9";
    else if (v.md == 3'd4)    tag = "R4";
    else                      tag = v.op32 ? "R2" : "R3";
    chk(tag, {61'd0, got_code}, {61'd0, v.ecode});
    if (v.ecode != 3'd0) begin
      chk("R11 fault seen, no bytes", {31'd0, saw_fault, 32'(ngot)}, {31'd0, 1'b1, 32'd0});
    end else begin
      n = (v.md == 3'd4) ? 10 : 6;
      chk({tag, " count"}, 64'(ngot), 64'(n));
      chk("R6 done seen", {63'd0, saw_done}, 64'd1);
      for (int k = 0; k < n && k < ngot; k++) begin
        chk((k < 2) ? "R1 limit byte" : {tag, " base byte"},
            {56'd0, got_data[k]}, {56'd0, exp_byte(v.md, v.op32, lim, b, k)});
        chk("R5 address", got_addr[k], v.addr + 64'(k));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t v;
    rst_n = 1'b0; start = 1'b0; mode = 3'd0; op32 = 1'b0; eaddr = '0;
    seg_is_ss = 1'b0; seg_limit_viol = 1'b0; seg_writable = 1'b1; seg_null_sel = 1'b0;
    cpl = 2'd0; ac_enable = 1'b0; lock_prefix = 1'b0; dest_is_reg = 1'b0;
    idt_limit = '0; idt_base = '0; wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R12 reset outputs", {58'd0, wr_valid, done, fault, fault_code}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i], 16'hC3A5 ^ 16'(i), 64'hF1E2_D3C4_B5A6_9788 + 64'(i), 1'b0, 1'b0);
      judge(VECS[i], 16'hC3A5 ^ 16'(i), 64'hF1E2_D3C4_B5A6_9788 + 64'(i));
    end

    // R5 back-pressure on a 10-byte image
    v = VECS[3];
    run_op(v, 16'h1234, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0);
    judge(v, 16'h1234, 64'h0123_4567_89AB_CDEF);

    // R6 start with lock during transfer is ignored
    v = VECS[2];
    run_op(v, 16'hBEEF, 64'h0000_0000_CAFE_F00D, 1'b0, 1'b1);
    judge(v, 16'hBEEF, 64'h0000_0000_CAFE_F00D);
    lock_prefix = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule